// File: doc/BRIEF.md
# Windowed I/O Port Decoder with LED Flip-Flop

This block watches the address and strobe lines of a small processor's I/O bus and turns any access that falls into one fixed 64-port window into a single active-low chip-select. The window is split into eight groups of eight consecutive ports, and each group has its own select line. The select lines are combinational from the bus, so they are low exactly as long as the qualifying access lasts.

Two of the select lines drive an LED flip-flop. When an access to the first group ends, the rising edge of its select sets the LED. This edge is found on the system clock after a short synchronizer. Any access to the second group clears the LED at once, without waiting for a clock, and this clear overrides any pending set. Software blinks the LED by writing to the two groups in turn, with its own delay between the writes.

Top module: `io_window_decoder`

## Requirements
- R1: A select goes low only for port addresses 280H to 2BFH inclusive; 27FH, 2C0H and all other addresses leave `sel_n` at 8'hFF.
- R2: Inside the window, `sel_n[k]` is the one that goes low for addresses 280H+8k through 280H+8k+7, which means it is chosen by `addr[5:3]` when `addr[9:6]` is 4'b1010.
- R3: At any time at most one bit of `sel_n` is low, and every other bit is high.
- R4: A select is low only while `rd_n` or `wr_n` is low and `aen` is low. It follows the bus inputs in the same cycle, with no clock delay.
- R5: When `sel_n[0]` goes from low back to high, `led` goes to 1 on the third rising clock edge after the release, and not before.
- R6: While `sel_n[1]` is low, `led` is 0 immediately and without a clock edge. This clear wins over a set still in flight from a recent `sel_n[0]` release.
- R7: While `rst_n` is low, `led` is 0 and `sel_n` is 8'hFF whatever the bus does.
- R8: `led` holds its value while the bus is idle and during accesses to the groups selected by `sel_n[7:2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | I/O port address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| aen | input | 1 | Address-enable qualifier; high means the cycle is not a processor I/O cycle |
| sel_n | output | 8 | Active-low group selects, bit k for ports 280H+8k..+7 |
| led | output | 1 | LED flip-flop state, 1 = on |

## Verification
The select lines hold no state, so a decode fault shows up on `sel_n` in the same cycle as the access that triggers it. Likely signs are a wrong group low, two bits low at once, or a strobe at a window edge or with `aen` high. A fault in the synchronizer or in the edge history shows up on `led` as a set that comes one cycle early or late, or as a set with no preceding `sel_n[0]` pulse. Either way it is visible within a few clocks of the release. A broken clear path leaves `led` high while `sel_n[1]` is low, which is visible on the next sample.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int unsigned IO_ADDR_W   = 10;
  localparam int unsigned IO_NUM_SEL  = 8;
  localparam int unsigned IO_GROUP_W  = 3;
  localparam logic [IO_ADDR_W-1:0] IO_WINDOW_BASE = 10'h280;
  localparam int unsigned IO_SYNC_STAGES = 2;
  localparam int unsigned IO_SET_SEL  = 0;
  localparam int unsigned IO_CLR_SEL  = 1;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/port_window_dec.sv
module port_window_dec #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_SEL = 8,
  parameter int unsigned GROUP_W = 3,
  parameter logic [ADDR_W-1:0] BASE = 10'h280
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               aen,
  input  logic               enable,
  output logic [NUM_SEL-1:0] sel_n
);
  localparam int unsigned SEL_W = $clog2(NUM_SEL);
  localparam int unsigned TAG_LO = GROUP_W + SEL_W;

  logic bus_cycle;
  logic tag_match;
  logic hit;

  always_comb begin
    bus_cycle = !(rd_n && wr_n);
    tag_match = (addr[ADDR_W-1:TAG_LO] == BASE[ADDR_W-1:TAG_LO]);
    hit       = enable && bus_cycle && !aen && tag_match;
  end

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
    assign sel_n[k] = !(hit && (addr[TAG_LO-1:GROUP_W] == SEL_W'(k)));
  end
endmodule

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic release_pulse
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    sync_d[0] = strobe_n;
    for (int i = 1; i < STAGES; i++) sync_d[i] = sync_q[i-1];
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign release_pulse = sync_q[STAGES-1] && !last_q;
endmodule

// File: rtl/led_flop.sv
module led_flop (
  input  logic clk,
  input  logic clr_n,
  input  logic set_en,
  output logic led
);
  logic led_q;
  logic led_d;

  always_comb led_d = 1'b1;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      led_q <= 1'b0;
    else if (set_en) led_q <= led_d;
  end

  assign led = led_q;
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import io_dec_pkg::*;
#(
  parameter int unsigned ADDR_W      = IO_ADDR_W,
  parameter int unsigned NUM_SEL     = IO_NUM_SEL,
  parameter int unsigned GROUP_W     = IO_GROUP_W,
  parameter logic [ADDR_W-1:0] BASE  = IO_WINDOW_BASE,
  parameter int unsigned SYNC_STAGES = IO_SYNC_STAGES,
  parameter int unsigned SET_SEL     = IO_SET_SEL,
  parameter int unsigned CLR_SEL     = IO_CLR_SEL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               aen,
  output logic [NUM_SEL-1:0] sel_n,
  output logic               led
);
  logic rst_sync_n;
  logic set_pulse;
  logic led_clr_n;

  rst_release_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  port_window_dec #(
    .ADDR_W  (ADDR_W),
    .NUM_SEL (NUM_SEL),
    .GROUP_W (GROUP_W),
    .BASE    (BASE)
  ) u_dec (
    .addr   (addr),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .aen    (aen),
    .enable (rst_sync_n),
    .sel_n  (sel_n)
  );

  strobe_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .strobe_n      (sel_n[SET_SEL]),
    .release_pulse (set_pulse)
  );

  assign led_clr_n = rst_sync_n && sel_n[CLR_SEL];

  led_flop u_led (
    .clk    (clk),
    .clr_n  (led_clr_n),
    .set_en (set_pulse),
    .led    (led)
  );
endmodule

// File: rtl/io_window_decoder_checker.sv
module io_window_decoder_checker #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_SEL = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               rd_n,
  input logic               wr_n,
  input logic               aen,
  input logic [NUM_SEL-1:0] sel_n,
  input logic               led
);
  logic [3:0] since_set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          since_set_q <= 4'hF;
    else if (!sel_n[0])  since_set_q <= 4'h0;
    else if (since_set_q != 4'hF) since_set_q <= since_set_q + 4'h1;
  end

  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[9:6] != 4'b1010) |-> (&sel_n)); // R1
  AST_GROUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n != '1) |-> !sel_n[addr[5:3]]); // R2
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n)); // R3
  AST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (aen || (rd_n && wr_n)) |-> (&sel_n)); // R4
  AST_SET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led) |-> (since_set_q <= 4'(SYNC_STAGES + 1))); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n[1] |-> !led); // R6
endmodule

bind io_window_decoder io_window_decoder_checker #(
  .ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
  .aen(aen), .sel_n(sel_n), .led(led)
);

// File: tb/tb_io_window_decoder.sv
module tb_io_window_decoder;
  logic       clk;
  logic       rst_n;
  logic [9:0] addr;
  logic       rd_n;
  logic       wr_n;
  logic       aen;
  logic [7:0] sel_n;
  logic       led;

  int unsigned n_checks;
  int unsigned n_fail;

  io_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .aen(aen), .sel_n(sel_n), .led(led)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] exp_sel(input logic [9:0] a, input logic r,
                                         input logic w, input logic e);
    if ((!r || !w) && !e && a[9:6] == 4'b1010) return ~(8'b1 << a[5:3]);
    return 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic idle();
    addr = 10'h000; rd_n = 1'b1; wr_n = 1'b1; aen = 1'b0;
  endtask

  task automatic check_sel(input string req);
    #1 check(sel_n == exp_sel(addr, rd_n, wr_n, aen), req, 32'(sel_n),
             32'(exp_sel(addr, rd_n, wr_n, aen)));
  endtask

  // drive one write on a negedge, hold for n cycles, release on a negedge
  task automatic write_port(input logic [9:0] a, input int n);
    @(negedge clk);
    addr = a; wr_n = 1'b0; aen = 1'b0;
    repeat (n) @(negedge clk);
    idle();
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0;
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    addr = 10'h280; rd_n = 1'b1; wr_n = 1'b0; aen = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(sel_n == 8'hFF, "R7 reset selects", 32'(sel_n), 32'hFF);
    check(led == 1'b0, "R7 reset led", 32'(led), 32'h0);
    idle();
    @(negedge clk) rst_n = 1'b1;
    wait_cycles(4);

    // window edges and qualifier
    @(negedge clk); addr = 10'h27F; wr_n = 1'b0; check_sel("R1 27F");
    @(negedge clk); addr = 10'h2C0; check_sel("R1 2C0");
    @(negedge clk); addr = 10'h2BF; check_sel("R2 2BF");
    #1 check(sel_n == 8'h7F, "R2 top group", 32'(sel_n), 32'h7F);
    @(negedge clk); addr = 10'h2A5; aen = 1'b1; check_sel("R4 aen high");
    #1 check(sel_n == 8'hFF, "R4 aen blocks", 32'(sel_n), 32'hFF);
    @(negedge clk); aen = 1'b0; wr_n = 1'b1; rd_n = 1'b1; check_sel("R4 idle");
    @(negedge clk); rd_n = 1'b0; addr = 10'h2A5; check_sel("R4 read");
    #1 check(sel_n == 8'hEF, "R2 group 4 read", 32'(sel_n), 32'hEF);
    @(negedge clk); idle();

    // random decode
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      addr = ($urandom % 4 != 0) ? (10'h270 + 10'($urandom % 96)) : 10'($urandom);
      rd_n = 1'($urandom % 2);
      wr_n = 1'($urandom % 2);
      aen  = ($urandom % 5 == 0);
      #1;
      check(sel_n == exp_sel(addr, rd_n, wr_n, aen), "R1 R2 R4 random", 32'(sel_n),
            32'(exp_sel(addr, rd_n, wr_n, aen)));
      check($countones(~sel_n) <= 1, "R3 one select", 32'(sel_n), 32'hFF);
    end
    @(negedge clk); idle();

    // clear, then exact set latency
    write_port(10'h28C, 2);
    wait_cycles(2);
    check(led == 1'b0, "R6 cleared", 32'(led), 32'h0);
    write_port(10'h283, 2);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(led == 1'b0, "R5 not before third edge", 32'(led), 32'h0);
    @(posedge clk); @(negedge clk);
    check(led == 1'b1, "R5 set on third edge", 32'(led), 32'h1);

    // other groups and idle leave led alone
    for (int g = 2; g < 8; g++) begin
      write_port(10'h280 + 10'(g * 8), 2);
      wait_cycles(4);
      check(led == 1'b1, "R8 other group holds", 32'(led), 32'h1);
    end

    // asynchronous clear
    @(negedge clk); addr = 10'h289; wr_n = 1'b0;
    #1 check(led == 1'b0, "R6 immediate clear", 32'(led), 32'h0);
    @(negedge clk); idle();
    wait_cycles(5);
    check(led == 1'b0, "R8 off holds", 32'(led), 32'h0);

    // blink sequence
    for (int b = 0; b < 3; b++) begin
      write_port(10'h280, 1);
      wait_cycles(4);
      check(led == 1'b1, "R5 blink on", 32'(led), 32'h1);
      write_port(10'h28F, 1);
      #1 check(led == 1'b0, "R6 blink off", 32'(led), 32'h0);
    end

    // clear overrides a set still in flight
    write_port(10'h287, 2);
    @(negedge clk); addr = 10'h288; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    idle();
    wait_cycles(4);
    check(led == 1'b0, "R6 clear beats pending set", 32'(led), 32'h0);

    // reset while on
    write_port(10'h280, 1);
    wait_cycles(4);
    @(negedge clk); rst_n = 1'b0;
    #1 check(led == 1'b0, "R7 reset clears led", 32'(led), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    wait_cycles(3);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule